// File: doc/BRIEF.md
# Register-Bound I/O Ports with Strobes

This block is the port interface of a small 8-bit core. It has four input buses and four output buses, each a byte wide. Each pair is tied to one general-purpose register, so the register index given with a request is also the port number. Nothing else selects a port. The core issues either a read request, which takes a byte from input port n into the core, or a write request, which places a byte from register n onto output port n.

Every transfer is marked by its own active-low strobe, one per input port and one per output port. Strobes idle high and fall for exactly one clock. On a read, the input byte is captured on the same edge that pulls that input strobe low. The external side takes the falling edge to mean that the byte has been consumed and that it may present the next one. On a write, the output byte is registered one cycle before the output strobe falls. It is held through the low cycle, and the external side captures it there.

Only one port transfer is accepted per cycle. A request that would break the one-cycle pulse or the stability rule is dropped and flagged with an error pulse.

Top module: `io_strobe_ports`

## Requirements
- R1: After reset (asynchronous, active low), all eight strobes are high, every output bus is 0x00, `rd_data_o` is 0x00 and `err_o` is low.
- R2: An accepted read of port n (`reg_idx_i` = n) loads bits [8n+7:8n] of `in_bus_i` into `rd_data_o` on the next edge. `in_stb_no[n]` is low for exactly that one following cycle, and the other input strobes stay high.
- R3: An accepted write to port n drives `wr_data_i` onto `out_bus_o[8n+7:8n]` on the next edge. `out_stb_no[n]` falls one cycle later and stays low for exactly one cycle.
- R4: An output byte does not change between the edge that registers it and the end of its strobe's low cycle.
- R5: A cycle with both `rd_req_i` and `wr_req_i` high moves no data and pulls no strobe low. It raises `err_o` for one cycle after that edge.
- R6: A read of port n while `in_stb_no[n]` is low is rejected. The port's strobe rises as normal, `rd_data_o` keeps its value, and `err_o` is high for one cycle.
- R7: A write to port n in the cycle right after an accepted write to port n is rejected. The output byte keeps the first value, only one strobe pulse follows, and `err_o` is high for one cycle.
- R8: At most one input strobe and at most one output strobe are low in any cycle. Back-to-back transfers to different ports are all accepted.
- R9: `rd_data_o` keeps the last captured byte until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request from the core |
| wr_req_i | input | 1 | Write request from the core |
| reg_idx_i | input | 2 | Register index, which is also the port number |
| wr_data_i | input | 8 | Byte to send on a write |
| in_bus_i | input | 32 | Input ports; port n occupies bits [8n+7:8n] |
| rd_data_o | output | 8 | Last byte captured from an input port |
| out_bus_o | output | 32 | Output ports; port n occupies bits [8n+7:8n] |
| in_stb_no | output | 4 | Input strobes, active low, one per port |
| out_stb_no | output | 4 | Output strobes, active low, one per port |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
A wrong pending bit in an output slot shows as a missing, doubled or late output strobe one or two cycles after the write. It can also show as a valid second write that is wrongly rejected, which raises `err_o` on the next cycle. A bad read-side strobe register shows at once: a strobe stays low for two cycles, or an idle port pulses. A faulty capture path puts the wrong byte on `rd_data_o` on the edge right after the request. Because each of these faults surfaces within two cycles at the ports, the bench samples every cycle after each request.

// File: rtl/io_ports_pkg.sv
package io_ports_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLASH = 2'd3
  } io_op_e;
endpackage

// File: rtl/io_req_decode.sv
module io_req_decode
  import io_ports_pkg::*;
#(
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic [IW-1:0] idx_i,
  input  logic [NP-1:0] in_stb_ni,
  input  logic [NP-1:0] out_pend_i,
  output logic [NP-1:0] sel_o,
  output logic          rd_go_o,
  output logic          wr_go_o,
  output logic          err_set_o
);
  io_op_e op;

  always_comb begin
    unique case ({wr_req_i, rd_req_i})
      2'b01:   op = OP_READ;
      2'b10:   op = OP_WRITE;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
  end

  always_comb begin
    sel_o     = '0;
    sel_o[idx_i] = 1'b1;
    // a port still inside its pulse (read) or pending phase (write) is busy
    rd_go_o   = (op == OP_READ)  &&  in_stb_ni[idx_i];
    wr_go_o   = (op == OP_WRITE) && !out_pend_i[idx_i];
    err_set_o = (op == OP_CLASH)
             || ((op == OP_READ)  && !in_stb_ni[idx_i])
             || ((op == OP_WRITE) &&  out_pend_i[idx_i]);
  end
endmodule

// File: rtl/io_in_capture.sv
module io_in_capture #(
  parameter int DW = 8,
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_go_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [NP-1:0]    sel_i,
  input  logic [NP*DW-1:0] in_bus_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NP-1:0]    in_stb_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      in_stb_no <= '1;
    end else begin
      if (rd_go_i) rd_data_o <= in_bus_i[idx_i*DW +: DW];
      // sample and strobe fall share one edge
      in_stb_no <= ~(sel_i & {NP{rd_go_i}});
    end
  end
endmodule

// File: rtl/io_out_slot.sv
module io_out_slot #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] bus_o,
  output logic          pend_o,
  output logic          stb_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o  <= '0;
      pend_o <= 1'b0;
      stb_no <= 1'b1;
    end else begin
      if (go_i) bus_o <= data_i;
      pend_o <= go_i;
      stb_no <= ~pend_o;
    end
  end
endmodule

// File: rtl/io_strobe_ports.sv
module io_strobe_ports #(
  parameter int DW = 8,
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic [IW-1:0]    reg_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [NP*DW-1:0] in_bus_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NP*DW-1:0] out_bus_o,
  output logic [NP-1:0]    in_stb_no,
  output logic [NP-1:0]    out_stb_no,
  output logic             err_o
);
  logic [NP-1:0] sel;
  logic [NP-1:0] out_pend;
  logic          rd_go, wr_go, err_set;

  io_req_decode #(.NP(NP)) u_dec (
    .rd_req_i  (rd_req_i),
    .wr_req_i  (wr_req_i),
    .idx_i     (reg_idx_i),
    .in_stb_ni (in_stb_no),
    .out_pend_i(out_pend),
    .sel_o     (sel),
    .rd_go_o   (rd_go),
    .wr_go_o   (wr_go),
    .err_set_o (err_set)
  );

  io_in_capture #(.DW(DW), .NP(NP)) u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_go_i  (rd_go),
    .idx_i    (reg_idx_i),
    .sel_i    (sel),
    .in_bus_i (in_bus_i),
    .rd_data_o(rd_data_o),
    .in_stb_no(in_stb_no)
  );

  for (genvar k = 0; k < NP; k++) begin : g_out
    io_out_slot #(.DW(DW)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .go_i  (wr_go && sel[k]),
      .data_i(wr_data_i),
      .bus_o (out_bus_o[k*DW +: DW]),
      .pend_o(out_pend[k]),
      .stb_no(out_stb_no[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= err_set;
  end
endmodule

// File: rtl/io_strobe_ports_chk.sv
module io_strobe_ports_chk #(
  parameter int DW = 8,
  parameter int NP = 4,
  localparam int IW = $clog2(NP)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_req_i,
  input logic             wr_req_i,
  input logic [IW-1:0]    reg_idx_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [NP*DW-1:0] in_bus_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [NP*DW-1:0] out_bus_o,
  input logic [NP-1:0]    in_stb_no,
  input logic [NP-1:0]    out_stb_no,
  input logic             err_o
);
  logic [DW-1:0] in_sel;
  logic          rd_only, wr_only, idx_in_low;
  assign in_sel     = in_bus_i[reg_idx_i*DW +: DW];
  assign rd_only    = rd_req_i && !wr_req_i;
  assign wr_only    = wr_req_i && !rd_req_i;
  assign idx_in_low = !in_stb_no[reg_idx_i];

  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && !idx_in_low) |=> (rd_data_o == $past(in_sel)) && !in_stb_no[$past(reg_idx_i)]); // R2
  AST_IN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stb_no != '1) |=> ((~in_stb_no & ~$past(in_stb_no)) == '0)); // R2
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_stb_no != '1) |=> ((~out_stb_no & ~$past(out_stb_no)) == '0)); // R3
  AST_WR_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_only && out_stb_no == '1 && $stable(out_bus_o)) |=> (out_bus_o[$past(reg_idx_i)*DW +: DW] == $past(wr_data_i))); // R3
  for (genvar k = 0; k < NP; k++) begin : g_stable
    AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_stb_no[k] |-> $stable(out_bus_o[k*DW +: DW])); // R4
  end
  AST_CLASH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && wr_req_i) |=> err_o && $stable(out_bus_o) && (in_stb_no == '1) && $stable(rd_data_o)); // R5
  AST_RD_BUSY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && idx_in_low) |=> err_o && $stable(rd_data_o)); // R6
  AST_IN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~in_stb_no) <= 1); // R8
  AST_OUT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~out_stb_no) <= 1); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o)); // R9
endmodule

bind io_strobe_ports io_strobe_ports_chk #(.DW(DW), .NP(NP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_i  (rd_req_i),
  .wr_req_i  (wr_req_i),
  .reg_idx_i (reg_idx_i),
  .wr_data_i (wr_data_i),
  .in_bus_i  (in_bus_i),
  .rd_data_o (rd_data_o),
  .out_bus_o (out_bus_o),
  .in_stb_no (in_stb_no),
  .out_stb_no(out_stb_no),
  .err_o     (err_o)
);

// File: tb/io_strobe_ports_tb_top.sv
`timescale 1ns/1ps
module io_strobe_ports_tb_top;
  localparam int DW = 8;
  localparam int NP = 4;
  localparam int NV = 8;
  // [10] write, [9:8] port, [7:0] byte
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'hA5}, {1'b0, 2'd3, 8'h5A},
    {1'b1, 2'd1, 8'hC3}, {1'b1, 2'd2, 8'h0F},
    {1'b0, 2'd2, 8'hFF}, {1'b1, 2'd0, 8'h81},
    {1'b1, 2'd3, 8'h7E}, {1'b0, 2'd1, 8'h00}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rd_req_i = 1'b0, wr_req_i = 1'b0;
  logic [1:0]       reg_idx_i = '0;
  logic [DW-1:0]    wr_data_i = '0;
  logic [NP*DW-1:0] in_bus_i = '0;
  logic [DW-1:0]    rd_data_o;
  logic [NP*DW-1:0] out_bus_o;
  logic [NP-1:0]    in_stb_no, out_stb_no;
  logic             err_o;

  int n_chk = 0, n_err = 0;
  logic [NP*DW-1:0] exp_out = '0;
  logic [DW-1:0]    exp_rd = '0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  io_strobe_ports #(.DW(DW), .NP(NP)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic req(input bit rd, input bit wr, input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    rd_req_i = rd; wr_req_i = wr; reg_idx_i = idx; wr_data_i = d;
    @(posedge clk_i); #1;
    rd_req_i = 0; wr_req_i = 0;
  endtask

  function automatic logic [3:0] low(input int k);
    return ~(4'b1 << k);
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    step();
    chk(in_stb_no == '1 && out_stb_no == '1, "R1 strobes idle", {in_stb_no, out_stb_no}, 8'hFF);
    chk(out_bus_o == '0 && rd_data_o == '0 && !err_o, "R1 outputs zero", {out_bus_o, rd_data_o, err_o}, 0);

    for (int v = 0; v < NV; v++) begin
      logic w; logic [1:0] p; logic [7:0] b;
      {w, p, b} = VEC[v];
      if (!w) begin
        for (int k = 0; k < NP; k++) in_bus_i[k*DW +: DW] = (k == p) ? b : ~b;
        req(1, 0, p, 8'h00);
        exp_rd = b;
        chk(rd_data_o == b, "R2 read byte", rd_data_o, b);
        chk(in_stb_no == low(p), "R2 input strobe low", in_stb_no, low(p));
        chk(!err_o && out_stb_no == '1, "R2 no side effects", {err_o, out_stb_no}, 4'hF);
        step();
        chk(in_stb_no == '1, "R2 strobe one cycle", in_stb_no, 4'hF);
        chk(rd_data_o == exp_rd, "R9 read data held", rd_data_o, exp_rd);
      end else begin
        req(0, 1, p, b);
        exp_out[p*DW +: DW] = b;
        chk(out_bus_o == exp_out, "R3 output byte", out_bus_o, exp_out);
        chk(out_stb_no == '1, "R3 strobe still high", out_stb_no, 4'hF);
        step();
        chk(out_stb_no == low(p), "R3 output strobe low", out_stb_no, low(p));
        chk(out_bus_o == exp_out, "R4 stable in low cycle", out_bus_o, exp_out);
        step();
        chk(out_stb_no == '1, "R3 strobe one cycle", out_stb_no, 4'hF);
      end
    end

    // R5 clash
    req(1, 1, 2'd2, 8'h3C);
    chk(err_o == 1'b1, "R5 clash error", err_o, 1);
    chk(in_stb_no == '1 && out_bus_o == exp_out && rd_data_o == exp_rd, "R5 nothing moved",
        out_bus_o, exp_out);
    step();
    chk(!err_o && out_stb_no == '1, "R5 error one cycle, no pulse", {err_o, out_stb_no}, 4'hF);

    // R6 read while strobe low
    in_bus_i = 32'h44_33_22_11;
    req(1, 0, 2'd1, 8'h00);
    exp_rd = 8'h22;
    chk(rd_data_o == exp_rd, "R6 first read", rd_data_o, exp_rd);
    in_bus_i = 32'h99_88_77_66;
    req(1, 0, 2'd1, 8'h00);
    chk(err_o == 1'b1, "R6 busy read error", err_o, 1);
    chk(rd_data_o == exp_rd, "R6 data kept", rd_data_o, exp_rd);
    chk(in_stb_no == '1, "R6 strobe rises", in_stb_no, 4'hF);

    // R7 write to pending port
    req(0, 1, 2'd3, 8'h11);
    exp_out[3*DW +: DW] = 8'h11;
    req(0, 1, 2'd3, 8'h22);
    chk(err_o == 1'b1, "R7 pending write error", err_o, 1);
    chk(out_bus_o == exp_out, "R7 first byte kept", out_bus_o, exp_out);
    chk(out_stb_no == low(3), "R7 first pulse", out_stb_no, low(3));
    step();
    chk(out_stb_no == '1, "R7 pulse ends", out_stb_no, 4'hF);
    step();
    chk(out_stb_no == '1 && out_bus_o == exp_out, "R7 no second pulse", out_stb_no, 4'hF);

    // R8 back-to-back, different ports
    req(0, 1, 2'd0, 8'h55);
    req(0, 1, 2'd1, 8'h66);
    exp_out[0 +: DW] = 8'h55; exp_out[DW +: DW] = 8'h66;
    chk(!err_o && out_stb_no == low(0), "R8 write 0 pulse", out_stb_no, low(0));
    chk(out_bus_o == exp_out, "R8 both bytes", out_bus_o, exp_out);
    step();
    chk(out_stb_no == low(1), "R8 write 1 pulse", out_stb_no, low(1));
    in_bus_i = 32'hDE_AD_BE_EF;
    req(1, 0, 2'd2, 8'h00);
    req(1, 0, 2'd3, 8'h00);
    chk(!err_o && in_stb_no == low(3), "R8 read 3 strobe", in_stb_no, low(3));
    chk(rd_data_o == 8'hDE, "R8 read 3 byte", rd_data_o, 8'hDE);

    // R1 asynchronous reset mid-run
    req(0, 1, 2'd2, 8'hEE);
    #1 rst_ni = 1'b0;
    #1;
    chk(out_bus_o == '0 && rd_data_o == '0 && !err_o, "R1 async reset outputs", out_bus_o, 0);
    chk(in_stb_no == '1 && out_stb_no == '1, "R1 async reset strobes", {in_stb_no, out_stb_no}, 8'hFF);
    step();
    rst_ni = 1'b1;
    step();
    chk(out_stb_no == '1, "R1 no pulse after reset", out_stb_no, 4'hF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule